// File: doc/BRIEF.md
# Grouped Interrupt Mask Controller

This block gathers level-sensitive interrupt sources into three groups: eight transmit channels, eight receive channels and a two-bit DMA group whose bit 1 carries the host-error condition. Each group keeps a registered copy of its sources, an enable mask, and one interrupt output line. The enable mask cannot be written directly. Software sets bits through a mask-set register and clears them through a separate mask-clear register, so that two agents can each change their own bits without a read-modify-write.

A vector register shows every pending masked source of all three groups in one word. Each output line gives a single-cycle pulse when its group has a masked source pending, and is then disarmed. A write to the end-of-interrupt register re-arms all lines. If a masked source is still pending, the line pulses again on the next clock. This prevents an interrupt storm while the handler runs and ensures no event is lost once the handler finishes.

Register access uses a flat bus with an 8-bit byte offset, a write strobe and a combinational read path.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset all enable masks read zero, all output lines are low, every group is armed and raw status reads zero.
- R2: The raw status word of a group (offset +0x0 in its window) returns the level its sources had one clock edge earlier. Channel n maps to bit n.
- R3: Writing the mask-set register (+0x8) sets every enable bit whose data bit is 1. Bits written as 0 keep their value.
- R4: Writing the mask-clear register (+0xC) clears every enable bit whose data bit is 1. Bits written as 0 keep their value.
- R5: Reading +0x8 or +0xC returns the current enable mask. Writes to +0x0 or +0x4 do not change any mask.
- R6: The masked status word (+0x4) equals raw status AND the enable mask.
- R7: The transmit window is 0x80–0x8C, the receive window is 0xA0–0xAC and the DMA window is 0xB0–0xBC, all word-aligned. The DMA group has two bits, and bit 1 is host error.
- R8: The vector word at 0x90 holds the transmit masked bits in [7:0], the receive masked bits in [15:8] and the DMA masked bits in [17:16]. All other bits are zero.
- R9: When a group is armed and has any masked bit pending, its line is high for exactly one cycle, one clock edge later, and the group becomes disarmed. A disarmed group keeps its line low.
- R10: A write of any data to 0x94 re-arms all three groups, so a still-pending group pulses on the edge after next. A read of 0x94 returns zero.
- R11: A read of any other offset returns zero, and a write to any other offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_src | input | 8 | Transmit channel interrupt levels |
| rx_src | input | 8 | Receive channel interrupt levels |
| dma_src | input | 2 | DMA sources, bit 1 host error |
| reg_addr | input | 8 | Register byte offset |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tx_irq | output | 1 | Transmit group interrupt pulse |
| rx_irq | output | 1 | Receive group interrupt pulse |
| dma_irq | output | 1 | DMA group interrupt pulse |

## Verification
The embedded properties check on every cycle the following rules:
- the set and clear writes touch only the bits given,
- the mask holds when neither register is written,
- raw status tracks the sources with one edge of delay,
- a disarmed group never pulses,
- an end-of-interrupt always leaves the groups armed,
- the address decode never selects two targets.

Some behaviours depend on the whole register file and on the sequence of operations, and only the bench scenarios show them. These include the read mux contents for every offset, the packing of the vector word, the absence of effect from writes to status and unmapped offsets, and the pulse, silence and re-pulse pattern around end-of-interrupt. The bench compares these against a cycle model on every clock.

// File: rtl/irqmc_pkg.sv
`timescale 1ns/1ps
package irqmc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // Register slot inside a 16-byte group window, chosen by addr[3:2]
  typedef enum logic [1:0] {
    REG_RAW = 2'd0,
    REG_MSK = 2'd1,
    REG_SET = 2'd2,
    REG_CLR = 2'd3
  } grp_reg_e;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return (a[ADDR_W-1:4] == base[ADDR_W-1:4]) && (a[1:0] == 2'b00);
  endfunction

  function automatic grp_reg_e slot_of(input logic [ADDR_W-1:0] a);
    return grp_reg_e'(a[3:2]);
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [3*ADDR_W-1:0] bases,
                                                input int g);
    return bases[g*ADDR_W +: ADDR_W];
  endfunction
endpackage

// File: rtl/irqmc_group.sv
`timescale 1ns/1ps
module irqmc_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wbits,
  input  logic         eoi_we,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, mask_q;
  logic         armed_q, irq_q;
  logic         pend_any, fire_evt;

  assign masked_o = raw_q & mask_q;
  assign pend_any = |masked_o;
  assign fire_evt = armed_q & pend_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      raw_q <= src;
      if (set_we)      mask_q <= mask_q | wbits;
      else if (clr_we) mask_q <= mask_q & ~wbits;
      irq_q <= fire_evt;
      if (eoi_we)        armed_q <= 1'b1;
      else if (fire_evt) armed_q <= 1'b0;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_set_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
  assert_set_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));
  assert_clr_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(wbits)) == '0));
  assert_clr_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));
  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask_q));
  assert_raw_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_o == $past(src)));
  assert_disarmed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !irq_o);
  assert_eoi_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we |=> armed_q);
endmodule

// File: rtl/irqmc_decode.sv
`timescale 1ns/1ps
module irqmc_decode
  import irqmc_pkg::*;
#(
  parameter int                    NGRP     = 3,
  parameter logic [NGRP*ADDR_W-1:0] BASES   = '0,
  parameter logic [ADDR_W-1:0]     VEC_ADDR = 8'h90,
  parameter logic [ADDR_W-1:0]     EOI_ADDR = 8'h94
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  output logic [NGRP-1:0]   grp_hit,
  output logic [NGRP-1:0]   set_we,
  output logic [NGRP-1:0]   clr_we,
  output grp_reg_e          slot,
  output logic              vec_hit,
  output logic              eoi_hit,
  output logic              eoi_we
);
  assign slot    = slot_of(addr);
  assign vec_hit = (addr == VEC_ADDR);
  assign eoi_hit = (addr == EOI_ADDR);
  assign eoi_we  = wen & eoi_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_hit
    assign grp_hit[g] = in_window(addr, BASES[g*ADDR_W +: ADDR_W]);
    assign set_we[g]  = wen & grp_hit[g] & (slot == REG_SET);
    assign clr_we[g]  = wen & grp_hit[g] & (slot == REG_CLR);
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
`timescale 1ns/1ps
module irq_mask_ctrl
  import irqmc_pkg::*;
#(
  parameter int              TX_CH    = 8,
  parameter int              RX_CH    = 8,
  parameter int              DMA_SRC  = 2,
  parameter logic [7:0]      TX_BASE  = 8'h80,
  parameter logic [7:0]      RX_BASE  = 8'hA0,
  parameter logic [7:0]      DMA_BASE = 8'hB0,
  parameter logic [7:0]      VEC_ADDR = 8'h90,
  parameter logic [7:0]      EOI_ADDR = 8'h94
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TX_CH-1:0]   tx_src,
  input  logic [RX_CH-1:0]   rx_src,
  input  logic [DMA_SRC-1:0] dma_src,
  input  logic [7:0]         reg_addr,
  input  logic               reg_wen,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               tx_irq,
  output logic               rx_irq,
  output logic               dma_irq
);
  localparam int NGRP = 3;
  localparam int TOT  = TX_CH + RX_CH + DMA_SRC;
  localparam logic [NGRP*ADDR_W-1:0] BASES = {DMA_BASE, RX_BASE, TX_BASE};

  logic [TOT-1:0]  all_src, raw_w, mask_w, masked_w;
  logic [NGRP-1:0] grp_hit, set_we, clr_we, irq_lines;
  logic [NGRP-1:0][DATA_W-1:0] grp_rd;
  grp_reg_e        slot;
  logic            vec_hit, eoi_hit, eoi_we;
  logic            unused_wdata;

  assign all_src      = {dma_src, rx_src, tx_src};
  assign unused_wdata = ^reg_wdata;

  irqmc_decode #(
    .NGRP(NGRP), .BASES(BASES), .VEC_ADDR(VEC_ADDR), .EOI_ADDR(EOI_ADDR)
  ) u_dec (
    .addr(reg_addr), .wen(reg_wen), .grp_hit(grp_hit), .set_we(set_we),
    .clr_we(clr_we), .slot(slot), .vec_hit(vec_hit), .eoi_hit(eoi_hit),
    .eoi_we(eoi_we)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int GW = (g == 0) ? TX_CH : (g == 1) ? RX_CH : DMA_SRC;
    localparam int GO = (g == 0) ? 0 : (g == 1) ? TX_CH : TX_CH + RX_CH;
    logic [GW-1:0] pick;

    irqmc_group #(.W(GW)) u_grp (
      .clk(clk), .rst_n(rst_n), .src(all_src[GO +: GW]),
      .set_we(set_we[g]), .clr_we(clr_we[g]), .wbits(reg_wdata[GW-1:0]),
      .eoi_we(eoi_we), .raw_o(raw_w[GO +: GW]), .mask_o(mask_w[GO +: GW]),
      .masked_o(masked_w[GO +: GW]), .irq_o(irq_lines[g])
    );

    always_comb begin
      case (slot)
        REG_RAW: pick = raw_w[GO +: GW];
        REG_MSK: pick = masked_w[GO +: GW];
        default: pick = mask_w[GO +: GW];
      endcase
    end
    assign grp_rd[g] = grp_hit[g] ? {{(DATA_W-GW){1'b0}}, pick} : '0;
  end

  always_comb begin
    reg_rdata = vec_hit ? {{(DATA_W-TOT){1'b0}}, masked_w} : '0;
    for (int g = 0; g < NGRP; g++) reg_rdata = reg_rdata | grp_rd[g];
  end

  assign tx_irq  = irq_lines[0];
  assign rx_irq  = irq_lines[1];
  assign dma_irq = irq_lines[2];

  assert_decode_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grp_hit, vec_hit, eoi_hit}));
  assert_eoi_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit |-> (reg_rdata == '0));
endmodule

// File: tb/irq_mask_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mask_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_src = '0, rx_src = '0;
  logic [1:0]  dma_src = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_irq, rx_irq, dma_irq;

  int nvec = 0, nerr = 0;
  bit done = 0;

  logic [7:0] m_raw [3];
  logic [7:0] m_mask[3];
  logic       m_arm [3];
  logic       m_irq [3];
  bit         last_eoi = 0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tx_src(tx_src), .rx_src(rx_src), .dma_src(dma_src),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq), .dma_irq(dma_irq)
  );

  function automatic logic [7:0] gmask(input int g);
    return (g == 2) ? 8'h03 : 8'hFF;
  endfunction

  // group index of an address, -1 if none
  function automatic int grp_of(input logic [7:0] a);
    if (a[1:0] != 2'b00) return -1;
    case (a[7:4])
      4'h8: return 0;
      4'hA: return 1;
      4'hB: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int g = grp_of(a);
    if (a == 8'h90)
      return {14'd0, m_raw[2][1:0] & m_mask[2][1:0],
              m_raw[1] & m_mask[1], m_raw[0] & m_mask[0]};
    if (g < 0) return 32'd0;
    case (a[3:2])
      2'd0:    return {24'd0, m_raw[g]};
      2'd1:    return {24'd0, m_raw[g] & m_mask[g]};
      default: return {24'd0, m_mask[g]};
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h90) return "R8";
    if (a == 8'h94) return "R10";
    if (grp_of(a) < 0) return "R11";
    case (a[3:2])
      2'd0:    return "R2";
      2'd1:    return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < 3; g++) begin
      m_raw[g] = '0; m_mask[g] = '0; m_arm[g] = 1'b1; m_irq[g] = 1'b0;
    end
  endtask

  // Called at a negedge: check reads and lines, drive this cycle, step model.
  task automatic cycle(input bit wr, input logic [7:0] waddr, input logic [31:0] wdata,
                       input logic [7:0] raddr, input string tag);
    logic [7:0] src[3];
    bit fire;
    reg_wen  = 1'b0;
    reg_addr = raddr;
    #1;
    chk((tag != "") ? tag : tag_of(raddr), reg_rdata, exp_read(raddr));
    chk(last_eoi ? "R10" : "R9", {29'd0, dma_irq, rx_irq, tx_irq},
        {29'd0, m_irq[2], m_irq[1], m_irq[0]});
    reg_wen = wr; reg_addr = waddr; reg_wdata = wdata;
    src[0] = tx_src; src[1] = rx_src; src[2] = {6'd0, dma_src};
    @(posedge clk);
    last_eoi = wr && (waddr == 8'h94);
    for (int g = 0; g < 3; g++) begin
      fire = m_arm[g] && ((m_raw[g] & m_mask[g]) != 0);
      m_irq[g] = fire;
      if (last_eoi) m_arm[g] = 1'b1;
      else if (fire) m_arm[g] = 1'b0;
      m_raw[g] = src[g] & gmask(g);
      if (wr && grp_of(waddr) == g && waddr[3:2] == 2'd2)
        m_mask[g] = m_mask[g] | (wdata[7:0] & gmask(g));
      if (wr && grp_of(waddr) == g && waddr[3:2] == 2'd3)
        m_mask[g] = m_mask[g] & ~wdata[7:0];
    end
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic idle(input logic [7:0] raddr, input string tag);
    cycle(1'b0, 8'h00, 32'd0, raddr, tag);
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 18)
      0: return 8'h80;  1: return 8'h84;  2: return 8'h88;  3: return 8'h8C;
      4: return 8'hA0;  5: return 8'hA4;  6: return 8'hA8;  7: return 8'hAC;
      8: return 8'hB0;  9: return 8'hB4; 10: return 8'hB8; 11: return 8'hBC;
      12: return 8'h90; 13: return 8'h94; 14: return 8'h8A;
      default: return 8'((r >> 8) & 32'hFF);
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    idle(8'h88, "R1");
    idle(8'hA8, "R1");
    idle(8'hBC, "R1");
    idle(8'h80, "R1");

    // R3: set accumulates, zero bits keep
    cycle(1'b1, 8'h88, 32'h05, 8'h00, "");
    cycle(1'b1, 8'h88, 32'h0A, 8'h00, "");
    idle(8'h8C, "R3");
    // R4: clear removes only the ones
    cycle(1'b1, 8'h8C, 32'h03, 8'h00, "");
    idle(8'h88, "R4");
    // R5: writes to status offsets leave the mask alone
    cycle(1'b1, 8'h80, 32'hFF, 8'h00, "");
    cycle(1'b1, 8'h84, 32'h00, 8'h00, "");
    idle(8'h8C, "R5");
    // R11: unmapped write has no effect
    cycle(1'b1, 8'hC8, 32'hFF, 8'h00, "");
    idle(8'h88, "R11");

    // R7: DMA host error at bit 1, receive channel 5 at bit 5
    cycle(1'b1, 8'hB8, 32'h2, 8'h00, "");
    cycle(1'b1, 8'hA8, 32'h20, 8'h00, "");
    dma_src = 2'b10; rx_src = 8'h20;
    idle(8'h00, "");
    idle(8'hB4, "R7");
    idle(8'hA4, "R7");
    idle(8'h90, "R8");
    // R9: transmit channel 3 pulses once then stays quiet
    tx_src = 8'h08;
    repeat (5) idle(8'h84, "");
    // R10: end-of-interrupt re-arms, pending groups pulse again
    cycle(1'b1, 8'h94, 32'h0, 8'h94, "R10");
    repeat (4) idle(8'h90, "");
    tx_src = '0; rx_src = '0; dma_src = '0;
    cycle(1'b1, 8'h94, 32'h1, 8'h00, "");
    repeat (3) idle(8'h90, "");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom;
      if ((r & 32'h3) == 0) begin
        tx_src  = 8'($urandom);
        rx_src  = 8'($urandom);
        dma_src = 2'($urandom);
      end
      cycle(((r >> 4) % 10) < 3, pick_addr($urandom), $urandom, pick_addr($urandom), "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule